// File: doc/BRIEF.md
# Triggered circular trace capture buffer

This block records a stream of trace frames into an on-chip circular RAM. While capture is enabled, every valid frame goes to the slot under the write pointer, and the pointer wraps at the end of the RAM, so the buffer always holds the most recent frames. A trigger pulse marks the event of interest. After the trigger the block stores a programmed number of further frames and then declares acquisition complete. From then on it ignores new frames, so the window around the trigger stays intact until the host reads it out.

A debug host reaches the block through a 40-bit serial register that has capture, shift and update strobes. Each update performs one register access, either a read or a write. A read is pipelined: its result comes out in the data field of the following scan. Reading the RAM data window returns the frame under the read pointer and then advances that pointer. A host can therefore stream the whole buffer with back-to-back scans, and it ends with a scan at a harmless address.

Top module: `trace_capture_buf`

## Requirements
- R1: The scan register is 40 bits and shifts LSB first. Bits [31:0] are data, bits [38:32] are the register address, and bit 39 is 1 for a write and 0 for a read. `scan_in` enters at bit 39 on each shift strobe, and `scan_out` shows bit 0. A capture strobe loads the pending read result into [31:0] and zeros into [39:32]. An update strobe performs the access that the register holds.
- R2: A read update latches the addressed register's value. That value is returned in the data field of the next scan's capture.
- R3: Register addresses are: 0 fixed identification value (default 0x7ACEB001), 1 RAM depth, 2 frame width, 3 status, 4 RAM data window, 5 read pointer, 6 write pointer, 7 post-trigger counter, 8 control. Unmapped addresses read as 0. After reset the pending read result, the control, both pointers, the counter and all flags are zero.
- R4: Writes to addresses 0 to 4 and to unmapped addresses change nothing. A write to address 4 does not move the read pointer.
- R5: A read of address 4 returns the frame stored at the read pointer and advances the read pointer by one, modulo the depth. The read pointer is writable.
- R6: While control bit 0 is set, each cycle with `trc_valid` high stores `trc_data` at the write pointer, and the write pointer then advances modulo the depth. The write pointer is writable. While control bit 0 is clear, frames are ignored.
- R7: Status bit 0 (full) is set when the write pointer wraps from depth-1 to 0. It stays set until capture is re-enabled.
- R8: A `trc_trigger` pulse while capture is enabled and not complete sets status bit 1 (triggered). The frame presented in the trigger cycle is stored but not counted.
- R9: After the trigger, each stored frame decrements the counter. When the counter is zero after a trigger, status bit 2 (complete) is set and all further frames are ignored. Exactly the programmed number of frames follows the trigger frame, and a count of 0 stores only the trigger frame.
- R10: Status bit 3 (formatter empty) is 1 when no accepted frame is waiting to be written. An accepted frame is written to the RAM in the cycle after it is accepted.
- R11: Writing control with bit 0 set while capture is disabled clears full, triggered and complete. Control reads back {bit 1 = demux select, bit 0 = enable}.
- R12: Writes to the pointers keep only the low log2(depth) bits of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_capture | input | 1 | Load the pending read result into the scan register |
| scan_shift | input | 1 | Shift the scan register one bit toward bit 0 |
| scan_update | input | 1 | Perform the access held in the scan register |
| scan_in | input | 1 | Serial input, enters at bit 39 |
| scan_out | output | 1 | Serial output, bit 0 of the scan register |
| trc_valid | input | 1 | Trace frame present this cycle |
| trc_data | input | WIDTH | Trace frame |
| trc_trigger | input | 1 | Trigger event pulse |

## Verification
A register read is due one full scan after its update, in the data field of the next capture. The bench therefore pairs every read with a following scan and compares only the bits shifted out of that second scan. A frame reaches the RAM one cycle after acceptance, and the complete flag rises one cycle after the counter reaches zero. After the last frame the bench idles three cycles before it starts any scan, and every scan itself spans 42 cycles, so all flags and pointers have settled when they are captured.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    localparam int SCAN_W = 40;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ID     = 7'd0,
        SEL_DEPTH  = 7'd1,
        SEL_WIDTH  = 7'd2,
        SEL_STATUS = 7'd3,
        SEL_DATA   = 7'd4,
        SEL_RDPTR  = 7'd5,
        SEL_WRPTR  = 7'd6,
        SEL_COUNT  = 7'd7,
        SEL_CTRL   = 7'd8
    } reg_sel_e;

    localparam int ST_FULL  = 0;
    localparam int ST_TRIG  = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_EMPTY = 3;
endpackage

// File: rtl/tcb_scan_port.sv
module tcb_scan_port
    import tcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              shf,
    input  logic              upd,
    input  logic              sin,
    input  logic [DATA_W-1:0] rdata,
    output logic              sout,
    output logic              req_v,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);
    logic [SCAN_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (cap) begin
            sr_d = {{(SCAN_W-DATA_W){1'b0}}, rdata};
        end else if (shf) begin
            sr_d = {sin, sr_q[SCAN_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sout     = sr_q[0];
    assign req_v    = upd;
    assign req_wr   = sr_q[SCAN_W-1];
    assign req_addr = sr_q[DATA_W +: ADDR_W];
    assign req_data = sr_q[DATA_W-1:0];
endmodule

// File: rtl/tcb_trace_ram.sv
module tcb_trace_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int          DEPTH    = 64,
    parameter int          WIDTH    = 32,
    parameter logic [31:0] ID_VALUE = 32'h7ACE_B001,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_capture,
    input  logic             scan_shift,
    input  logic             scan_update,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic             trc_valid,
    input  logic [WIDTH-1:0] trc_data,
    input  logic             trc_trigger
);
    typedef struct packed {
        logic              en;
        logic              demux;
        logic              full;
        logic              trig;
        logic              done;
        logic              pend_v;
        logic [WIDTH-1:0]  pend_data;
        logic [AW-1:0]     rd_ptr;
        logic [AW-1:0]     wr_ptr;
        logic [DATA_W-1:0] tcnt;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic              req_v, req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [WIDTH-1:0]  ram_wdata, ram_rdata;
    logic [DATA_W-1:0] reg_val;
    logic [3:0]        status;
    logic              cnt_zero, armed, accept;

    // observation names used by the bound checker
    logic          en_w, full_w, trig_w, done_w, pend_w;
    logic [AW-1:0] rdp_w, wrp_w;

    assign en_w   = st_q.en;
    assign full_w = st_q.full;
    assign trig_w = st_q.trig;
    assign done_w = st_q.done;
    assign pend_w = st_q.pend_v;
    assign rdp_w  = st_q.rd_ptr;
    assign wrp_w  = st_q.wr_ptr;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    tcb_scan_port u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (scan_capture),
        .shf      (scan_shift),
        .upd      (scan_update),
        .sin      (scan_in),
        .rdata    (st_q.rdata),
        .sout     (scan_out),
        .req_v    (req_v),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .req_data (req_data)
    );

    tcb_trace_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (st_q.rd_ptr),
        .rdata (ram_rdata)
    );

    assign status = {~pend_w, done_w, trig_w, full_w};

    always_comb begin
        case (reg_sel_e'(req_addr))
            SEL_ID:     reg_val = ID_VALUE;
            SEL_DEPTH:  reg_val = DATA_W'(DEPTH);
            SEL_WIDTH:  reg_val = DATA_W'(WIDTH);
            SEL_STATUS: reg_val = DATA_W'(status);
            SEL_DATA:   reg_val = DATA_W'(ram_rdata);
            SEL_RDPTR:  reg_val = DATA_W'(rdp_w);
            SEL_WRPTR:  reg_val = DATA_W'(wrp_w);
            SEL_COUNT:  reg_val = st_q.tcnt;
            SEL_CTRL:   reg_val = DATA_W'({st_q.demux, en_w});
            default:    reg_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;

        // write stage: frame accepted last cycle lands in RAM now
        ram_we    = st_q.pend_v;
        ram_waddr = st_q.wr_ptr;
        ram_wdata = st_q.pend_data;
        if (st_q.pend_v) begin
            st_d.wr_ptr = ptr_next(st_q.wr_ptr);
            if (st_q.wr_ptr == AW'(DEPTH-1)) st_d.full = 1'b1;
        end

        // accept stage
        cnt_zero = (st_q.tcnt == '0);
        armed    = st_q.en && !st_q.done && !(st_q.trig && cnt_zero);
        accept   = armed && trc_valid;
        st_d.pend_v = accept;
        if (accept) st_d.pend_data = trc_data;
        if (accept && st_q.trig) st_d.tcnt = st_q.tcnt - 1'b1;
        if (st_q.en && !st_q.done && trc_trigger) st_d.trig = 1'b1;
        if (st_q.en && st_q.trig && cnt_zero) st_d.done = 1'b1;

        // register access from the scan port
        if (req_v) begin
            if (req_wr) begin
                case (reg_sel_e'(req_addr))
                    SEL_RDPTR: st_d.rd_ptr = req_data[AW-1:0];
                    SEL_WRPTR: st_d.wr_ptr = req_data[AW-1:0];
                    SEL_COUNT: st_d.tcnt   = req_data;
                    SEL_CTRL: begin
                        st_d.en    = req_data[0];
                        st_d.demux = req_data[1];
                        if (req_data[0] && !st_q.en) begin
                            st_d.full = 1'b0;
                            st_d.trig = 1'b0;
                            st_d.done = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else begin
                st_d.rdata = reg_val;
                if (reg_sel_e'(req_addr) == SEL_DATA) st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
    parameter int  DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_v,
    input logic          req_wr,
    input logic [6:0]    req_addr,
    input logic          en,
    input logic          full,
    input logic          trig,
    input logic          done,
    input logic          pend,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] wr_ptr
);
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> done);

    assert_done_needs_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> trig);

    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && en) |=> full);

    assert_frozen_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pend && !(req_v && req_wr && req_addr == 7'd6)) |=> $stable(wr_ptr));

    assert_window_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_v && !req_wr && req_addr == 7'd4) |=>
        (rd_ptr == (($past(rd_ptr) == AW'(DEPTH-1)) ? AW'(0) : AW'($past(rd_ptr) + 1'b1))));

    assert_idle_no_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pend);
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_v    (req_v),
    .req_wr   (req_wr),
    .req_addr (req_addr),
    .en       (en_w),
    .full     (full_w),
    .trig     (trig_w),
    .done     (done_w),
    .pend     (pend_w),
    .rd_ptr   (rdp_w),
    .wr_ptr   (wrp_w)
);

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;
    localparam int          DEPTH = 64;
    localparam int          WIDTH = 32;
    localparam logic [31:0] IDV   = 32'h7ACE_B001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap = 1'b0, shf = 1'b0, upd = 1'b0, sin = 1'b0;
    logic sout;
    logic tv = 1'b0, tt = 1'b0;
    logic [WIDTH-1:0] td = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trace_capture_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_VALUE(IDV)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_capture (cap),
        .scan_shift   (shf),
        .scan_update  (upd),
        .scan_in      (sin),
        .scan_out     (sout),
        .trc_valid    (tv),
        .trc_data     (td),
        .trc_trigger  (tt)
    );

    typedef struct packed {
        logic        wr;
        logic [6:0]  wa;
        logic [6:0]  ra;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 7'd0, 7'd0, 32'h0,        IDV,          8'd3},  // R3 identification
        '{1'b0, 7'd0, 7'd1, 32'h0,        32'd64,       8'd3},  // R3 depth
        '{1'b0, 7'd0, 7'd2, 32'h0,        32'd32,       8'd3},  // R3 width
        '{1'b1, 7'd0, 7'd0, 32'hFFFFFFFF, IDV,          8'd4},  // R4 id write ignored
        '{1'b1, 7'd1, 7'd1, 32'h5,        32'd64,       8'd4},  // R4 depth write ignored
        '{1'b1, 7'd3, 7'd3, 32'hF,        32'h8,        8'd4},  // R4 status write ignored
        '{1'b1, 7'd5, 7'd5, 32'd13,       32'd13,       8'd5},  // R5 read pointer write
        '{1'b1, 7'd4, 7'd5, 32'h77,       32'd13,       8'd4},  // R4 data write no advance
        '{1'b1, 7'd5, 7'd5, 32'd70,       32'd6,        8'd12}, // R12 pointer truncation
        '{1'b1, 7'd6, 7'd6, 32'd9,        32'd9,        8'd6},  // R6 write pointer write
        '{1'b1, 7'd7, 7'd7, 32'h1234,     32'h1234,     8'd9},  // R9 counter write
        '{1'b1, 7'd8, 7'd8, 32'h2,        32'h2,        8'd11}, // R11 control readback
        '{1'b1, 7'd9, 7'd9, 32'hABCD,     32'h0,        8'd3}   // R3 unmapped reads zero
    };

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic scan(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        output logic [39:0] q);
        logic [39:0] v;
        v = {wr, a, d};
        @(negedge clk);
        cap = 1'b1;
        @(negedge clk);
        cap = 1'b0;
        shf = 1'b1;
        for (int i = 0; i < 40; i++) begin
            sin  = v[i];
            q[i] = sout;
            @(negedge clk);
        end
        shf = 1'b0;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic wreg(input logic [6:0] a, input logic [31:0] d);
        logic [39:0] q;
        scan(1'b1, a, d, q);
    endtask

    task automatic rreg(input logic [6:0] a, output logic [31:0] v);
        logic [39:0] q;
        scan(1'b0, a, 32'h0, q);
        scan(1'b0, 7'd0, 32'h0, q);
        v = q[31:0];
    endtask

    task automatic send(input int n, input logic [31:0] base, input int trig_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tv = 1'b1;
            td = base + i;
            tt = (i == trig_at);
        end
        @(negedge clk);
        tv = 1'b0;
        tt = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic readout(input string tag, input int start, input int n, input logic [31:0] base);
        logic [39:0] q;
        wreg(7'd5, start);
        scan(1'b0, 7'd4, 32'h0, q);
        for (int j = 1; j < n; j++) begin
            scan(1'b0, 7'd4, 32'h0, q);
            check(tag, {8'h0, q[31:0]}, {8'h0, base + j - 1});
        end
        scan(1'b0, 7'd0, 32'h0, q);
        check(tag, {8'h0, q[31:0]}, {8'h0, base + n - 1});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        logic [39:0] q;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state, R1 R3 R10
        scan(1'b0, 7'd3, 32'h0, q);
        check("R1 first capture all zero", q, 40'h0);
        scan(1'b0, 7'd8, 32'h0, q);
        check("R10 status after reset", q, 40'h8);
        scan(1'b0, 7'd6, 32'h0, q);
        check("R3 control after reset", q, 40'h0);
        scan(1'b0, 7'd7, 32'h0, q);
        check("R3 write pointer after reset", q, 40'h0);
        scan(1'b0, 7'd0, 32'h0, q);
        check("R2 counter after reset", q, 40'h0);

        // register table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) wreg(VEC[k].wa, VEC[k].d);
            rreg(VEC[k].ra, v);
            n_chk++;
            if (v !== VEC[k].e) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: got 0x%0h expected 0x%0h", VEC[k].rq, k, v, VEC[k].e);
            end
        end

        // R8 R9 R6: trigger at frame 2, three post-trigger frames
        wreg(7'd6, 32'd0);
        wreg(7'd7, 32'd3);
        wreg(7'd8, 32'd1);
        send(10, 32'hA000, 2);
        rreg(7'd3, v);
        check("R9 status after completion", {8'h0, v}, 40'hE);
        rreg(7'd6, v);
        check("R9 six frames stored", {8'h0, v}, 40'd6);
        rreg(7'd7, v);
        check("R9 counter drained", {8'h0, v}, 40'd0);
        readout("R5 linear readout", 0, 6, 32'hA000);

        // R7 R11: overflow, trigger on first frame, 70 after it
        wreg(7'd8, 32'd0);
        wreg(7'd6, 32'd0);
        wreg(7'd7, 32'd70);
        wreg(7'd8, 32'd1);
        rreg(7'd3, v);
        check("R11 re-enable clears flags", {8'h0, v}, 40'h8);
        send(80, 32'h1000, 0);
        rreg(7'd3, v);
        check("R7 full after wrap", {8'h0, v}, 40'hF);
        rreg(7'd6, v);
        check("R7 write pointer at oldest", {8'h0, v}, 40'd7);
        readout("R7 wrapped readout", 7, DEPTH, 32'h1007);

        // R9: zero count keeps only the trigger frame
        wreg(7'd8, 32'd0);
        wreg(7'd6, 32'd0);
        wreg(7'd7, 32'd0);
        wreg(7'd8, 32'd1);
        send(6, 32'hB000, 0);
        rreg(7'd6, v);
        check("R9 zero count single frame", {8'h0, v}, 40'd1);
        rreg(7'd3, v);
        check("R9 status zero count", {8'h0, v}, 40'hE);
        readout("R9 trigger frame kept", 0, 1, 32'hB000);

        // R6: disabled capture ignores frames and triggers
        wreg(7'd8, 32'd0);
        wreg(7'd6, 32'd20);
        send(5, 32'hC000, 1);
        rreg(7'd6, v);
        check("R6 disabled ignores frames", {8'h0, v}, 40'd20);
        rreg(7'd8, v);
        check("R11 control disabled", {8'h0, v}, 40'd0);

        finish_run();
    end
endmodule